// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block holds the pending-interrupt state of a small peripheral and decides whether that peripheral requests service. Seven event sources each raise a sticky flag with a single-cycle set pulse. The sources are timers, a shift register and similar logic. A seven-bit enable mask selects which flags may assert the single interrupt output. The output is registered, so it follows a change in flags or enables one clock later.

Software reaches the block through a byte-wide register port with a one-bit register select. Select 0 is the flag register and select 1 is the enable register. Writes to the flag register clear flags by writing ones. Writes to the enable register either set or clear enable bits, as chosen by bit 7 of the written byte. Read data is combinational and always shows the selected register. Neighbouring decode logic can also clear individual flags with per-source strobes, for example when the shift-register data is read.

The interrupt output is produced by a two-state machine:
- IRQ_QUIET: the output is low.
- IRQ_RAISED: the output is high.
- Transition RAISE: IRQ_QUIET moves to IRQ_RAISED when any enabled flag is pending.
- Transition DROP: IRQ_RAISED moves to IRQ_QUIET when no enabled flag is pending.
- In either state, the machine holds its state while the pending condition is unchanged.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every flag and every enable bit is 0 and `irq_o` is 0. A flag read then returns 0x00 and an enable read returns 0x80.
- R2: A 1 on `src_set[i]` sets flag bit i at the next clock edge. A flag stays set until it is cleared, and no flag becomes set without its set pulse.
- R3: A write with `reg_sel`=0 clears each flag whose written bit (bits 6..0) is 1 and leaves the other flags unchanged. Written bit 7 has no effect.
- R4: A write with `reg_sel`=1 and data bit 7 = 1 enables every source whose written bit (bits 6..0) is 1 and leaves the other enables unchanged.
- R5: A write with `reg_sel`=1 and data bit 7 = 0 disables every source whose written bit (bits 6..0) is 1 and leaves the other enables unchanged. Enables change only on enable-register writes.
- R6: With `reg_sel`=1, `rd_data` is the enable bits in bits 6..0 with bit 7 forced to 1.
- R7: With `reg_sel`=0, `rd_data` bits 6..0 are the flags. Bit 7 is 1 exactly when some flag and its enable are both 1, and it reflects the current register contents in the same cycle, without the output register's delay.
- R8: A 1 on `rd_clr[i]` clears flag i at the next edge and leaves the other flags unchanged. This is the clear-on-read path, such as a shift-register data read.
- R9: When a set pulse and a clear arrive for the same flag in the same cycle, the set wins and the flag is 1 afterwards. The clear may come from a flag write or from `rd_clr`.
- R10: `irq_o` at each edge takes the value "any enabled flag pending" computed from the register contents before that edge. The output therefore rises and falls one cycle after the flag or enable change that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 7 | Per-source single-cycle set pulses |
| rd_clr | input | 7 | Per-source clear strobes from neighbouring read decode |
| reg_sel | input | 1 | Register select: 0 = flag register, 1 = enable register |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Composite read value of the selected register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach from the ports is a set pulse and a clear landing on the same flag in the same cycle. That situation is combined with the live summary bit moving one cycle ahead of the registered output. The bench drives `src_set` together with an all-ones flag write, and separately together with `rd_clr`, in a single cycle. It then checks, at consecutive cycles, that the flag read already shows the summary while `irq_o` still holds its old value. A sweep over all 128 enable masks crossed with a spread of flag patterns compares the composite reads and the delayed output against values computed arithmetically.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    // Register select encoding on the byte port
    typedef enum logic {
        SEL_FLAG   = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    // Interrupt output machine
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic            w1c_en,
    input  logic [NSRC-1:0] w1c_mask,
    input  logic [NSRC-1:0] rd_clr,
    output logic [NSRC-1:0] flags
);

    logic [NSRC-1:0] clear_mask;
    logic [NSRC-1:0] flags_next;

    // Clears from both paths merge; set is applied last so it wins
    always_comb begin
        clear_mask = rd_clr;
        if (w1c_en) begin
            clear_mask = clear_mask | w1c_mask;
        end
        flags_next = (flags & ~clear_mask) | src_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= flags_next;
        end
    end

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            set_not_clr,
    input  logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] enables
);

    logic [NSRC-1:0] enables_next;

    always_comb begin
        enables_next = enables;
        if (wr) begin
            if (set_not_clr) begin
                enables_next = enables | mask;
            end else begin
                enables_next = enables & ~mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enables <= '0;
        end else begin
            enables <= enables_next;
        end
    end

endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED; // RAISE
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;  // DROP
            default:    state_d = IRQ_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_flag_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NSRC  = DATA_W - 1
) (
    input  reg_sel_e          sel,
    input  logic [NSRC-1:0]   flags,
    input  logic [NSRC-1:0]   enables,
    input  logic              pending,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        unique case (sel)
            SEL_FLAG:   rd_data = {pending, flags};
            SEL_ENABLE: rd_data = {1'b1, enables};
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NSRC  = DATA_W - 1,
    localparam int TOP_B = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   rd_clr,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);

    reg_sel_e        sel;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    logic            pending;
    logic            flag_wr;
    logic            en_wr;

    assign sel     = reg_sel_e'(reg_sel);
    assign flag_wr = wr_en && (sel == SEL_FLAG);
    assign en_wr   = wr_en && (sel == SEL_ENABLE);
    assign pending = |(flag_q & en_q);

    irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_set  (src_set),
        .w1c_en   (flag_wr),
        .w1c_mask (wr_data[NSRC-1:0]),
        .rd_clr   (rd_clr),
        .flags    (flag_q)
    );

    irq_enable_bank #(.NSRC(NSRC)) u_enables (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (en_wr),
        .set_not_clr (wr_data[TOP_B]),
        .mask        (wr_data[NSRC-1:0]),
        .enables     (en_q)
    );

    irq_out_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq_o   (irq_o)
    );

    irq_read_mux #(.DATA_W(DATA_W)) u_rd (
        .sel     (sel),
        .flags   (flag_q),
        .enables (en_q),
        .pending (pending),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int DATA_W = 8,
    localparam int NSRC  = DATA_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_set,
    input logic [NSRC-1:0]   rd_clr,
    input logic              reg_sel,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_o,
    input logic [NSRC-1:0]   flags,
    input logic [NSRC-1:0]   enables
);

    // R2, R9: every pulsed source is set afterwards
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((flags & $past(src_set)) == $past(src_set)));

    // R2: no flag rises without its pulse
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(src_set)) == '0));

    // R3: written ones clear their flags when no set collides
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && src_set == '0)
        |=> ((flags & $past(wr_data[NSRC-1:0])) == '0));

    // R8: strobed flags are cleared when no set collides
    a_r8_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr != '0 && src_set == '0) |=> ((flags & $past(rd_clr)) == '0));

    // R4: set-style enable write
    a_r4_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && wr_data[DATA_W-1])
        |=> (enables == ($past(enables) | $past(wr_data[NSRC-1:0]))));

    // R5: clear-style enable write
    a_r5_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && !wr_data[DATA_W-1])
        |=> (enables == ($past(enables) & ~$past(wr_data[NSRC-1:0]))));

    // R5: enables hold without an enable write
    a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel) |=> $stable(enables));

    // R6: enable read composite
    a_r6_en_read: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (rd_data == {1'b1, enables}));

    // R7: flag read composite with live summary
    a_r7_flag_read: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (rd_data == {|(flags & enables), flags}));

    // R10: registered output lags the pending condition by one cycle
    a_r10_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(flags & enables))));

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_set (src_set),
    .rd_clr  (rd_clr),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_o   (irq_o),
    .flags   (flag_q),
    .enables (en_q)
);

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_set = '0;
    logic [6:0] rd_clr = '0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    irq_flag_ctrl dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_set (src_set),
        .rd_clr  (rd_clr),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Hold current inputs for one cycle, return just after the next negedge
    task automatic cycle();
        @(negedge clk);
        #0.5;
    endtask

    task automatic idle();
        wr_en = 1'b0; src_set = '0; rd_clr = '0;
    endtask

    task automatic write(input logic sel, input logic [7:0] d);
        idle();
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        cycle();
        idle();
    endtask

    function automatic logic [7:0] flag_view(input logic [6:0] f, input logic [6:0] e);
        return {|(f & e), f};
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [6:0] e_exp;
        logic [6:0] f_exp;
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();

        // R1: reset state
        reg_sel = 1'b0; #0.1;
        check("R1 flag read", rd_data, 8'h00);
        reg_sel = 1'b1; #0.1;
        check("R1 enable read", rd_data, 8'h80);
        check("R1 irq", irq_o, 0);

        // R2: sticky set
        src_set = 7'h41; cycle(); idle(); cycle();
        reg_sel = 1'b0; #0.1;
        check("R2 sticky flags", rd_data, 8'h41);

        // R3: write-one-to-clear, bit 7 ignored
        src_set = 7'h7F; cycle(); idle();
        write(1'b0, 8'hD5);
        reg_sel = 1'b0; #0.1;
        check("R3 w1c", rd_data, 8'h2A);

        // R4 / R5: set then clear enables
        write(1'b1, 8'h7F); // R5 clear all enables
        write(1'b1, 8'h8F);
        write(1'b1, 8'hB0);
        reg_sel = 1'b1; #0.1;
        check("R4 enable set", rd_data, 8'hBF);
        write(1'b1, 8'h05);
        reg_sel = 1'b1; #0.1;
        check("R5 enable clear", rd_data, 8'hBA);
        check("R6 enable read bit7", rd_data[7], 1);

        // R7 / R10: flags 0x2A, enables 0x3A -> pending; output already settled
        reg_sel = 1'b0; #0.1;
        check("R7 summary", rd_data, 8'hAA);
        check("R10 irq high", irq_o, 1);
        // Disable all: summary drops at once, irq one cycle later
        write(1'b1, 8'h7F);
        reg_sel = 1'b0; #0.1;
        check("R7 summary live", rd_data, 8'h2A);
        check("R10 irq lag", irq_o, 1);
        cycle();
        check("R10 irq drop", irq_o, 0);

        // R8: clear-on-read strobe for one source
        rd_clr = 7'h08; cycle(); idle();
        reg_sel = 1'b0; #0.1;
        check("R8 strobe clear", rd_data, 8'h22);

        // R9: set beats flag write in same cycle
        reg_sel = 1'b0; wr_data = 8'h7F; wr_en = 1'b1; src_set = 7'h10;
        cycle(); idle();
        reg_sel = 1'b0; #0.1;
        check("R9 set vs write", rd_data, 8'h10);
        // R9: set beats strobe clear
        rd_clr = 7'h10; src_set = 7'h10; cycle(); idle();
        #0.1;
        check("R9 set vs strobe", rd_data, 8'h10);
        rd_clr = 7'h10; cycle(); idle();
        #0.1;
        check("R8 strobe clears", rd_data, 8'h00);
        cycle();

        // Sweep: all enable masks against a spread of flag patterns
        for (int e = 0; e < 128; e++) begin
            for (int f = 0; f < 128; f += 9) begin
                e_exp = 7'(e);
                f_exp = 7'(f);
                write(1'b0, 8'hFF);
                write(1'b1, 8'h7F);
                write(1'b1, {1'b1, e_exp});
                src_set = f_exp; cycle(); idle();
                reg_sel = 1'b0; #0.1;
                check("R7 sweep flag read", rd_data, flag_view(f_exp, e_exp));
                check("R10 sweep irq before", irq_o, 0);
                cycle();
                check("R10 sweep irq after", irq_o, int'(|(f_exp & e_exp)));
                reg_sel = 1'b1; #0.1;
                check("R6 sweep enable read", rd_data, {1'b1, e_exp});
            end
        end

        // R1: reset again clears everything
        write(1'b1, 8'hFF);
        src_set = 7'h7F; cycle(); idle();
        rst_n = 1'b0; cycle(); rst_n = 1'b1; cycle();
        reg_sel = 1'b0; #0.1;
        check("R1 reset flags", rd_data, 8'h00);
        reg_sel = 1'b1; #0.1;
        check("R1 reset enables", rd_data, 8'h80);
        check("R1 reset irq", irq_o, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule